// File: doc/BRIEF.md
# Transaction-Aware Commit Monitor

This block watches the retirement stream of a multithreaded out-of-order core that runs hardware transactions. For every hardware thread it keeps two counters, one for retired transaction-begin instructions and one for retired transaction-end instructions. A thread is transactional while its begin count is ahead of its end count. Each cycle up to `COMMIT_WIDTH` instructions of one committing thread are presented, oldest in slot 0, and the counters advance in slot order.

Using that state, the monitor drops pending interrupts while the committing thread is inside a transaction. It rewrites any fault raised by a transactional instruction into a transactional-failure fault. It also checks that each instruction's transactional tag agrees with the thread state. An abort command clears a thread's counters and produces a fixed-form abort request for the data cache. The UID of each retiring begin instruction is reported to the memory side. Drain or thread-deactivate requests made while a thread is mid-transaction are flagged as errors. All pulse outputs are registered and appear one cycle after the inputs that cause them.

Top module: `txn_commit_monitor`

## Requirements
- R1: `in_txn_o[t]` is 1 exactly when thread t's begin count is greater than its end count. Both counts are 0 after reset. When `commit_tid_valid_i` is 0 the committing thread reads as not transactional, and no slot is counted.
- R2: Valid, fault-free slots update the committing thread's counters in slot order. A begin increments its count before that slot's tag check, and an end increments after it. A begin and an end in the same cycle both take effect, and `in_txn_o` reflects the update one cycle later.
- R3: A counted slot whose `ret_tagged_i` bit differs from the transactional state seen at its check raises `check_err_o` for one cycle, in the cycle after.
- R4: When `irq_pending_i` is 1 and the committing thread is transactional before this cycle's retirements, `irq_clear_o` and `spin_guard_o` pulse and `irq_take_o` stays 0. Otherwise a pending interrupt pulses `irq_take_o` only.
- R5: Fault code 0 means no fault and code 1 means transactional failure. Causes are 0 INVALID, 1 EXCEPTION, 2 SIZE, 3 MEMORY, 4 OTHER. A tagged faulting slot with a code other than 1 traps with code 1, cause 1 and the slot's UID. A tagged code-1 fault keeps its cause. An untagged fault passes its code and cause unchanged.
- R6: The oldest faulting slot drives the trap. That slot and every younger slot in the group are not counted.
- R7: `abort_cmd_i` clears both counters of `abort_tid_i`, and this overrides same-cycle retirements of that thread. The next cycle shows a request with address 0, byte count 8, attribute bits {abort, strictly ordered, physical} = 3'b111, and the given cause and UID.
- R8: When a counted begin retires, `last_uid_valid_o` pulses with the UID of the youngest counted begin in the group.
- R9: `drain_err_o` pulses when `drain_req_i` arrives while any thread is transactional. `deact_err_o` pulses when `deact_req_i` names a transactional thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| commit_tid_i | input | TID_W | Committing thread |
| commit_tid_valid_i | input | 1 | Committing thread ID is valid |
| ret_valid_i | input | COMMIT_WIDTH | Slot holds a retiring instruction |
| ret_start_i | input | COMMIT_WIDTH | Slot is a transaction begin |
| ret_stop_i | input | COMMIT_WIDTH | Slot is a transaction end |
| ret_tagged_i | input | COMMIT_WIDTH | Slot was issued in transactional state |
| ret_fault_i | input | COMMIT_WIDTH*4 | Per-slot fault code |
| ret_cause_i | input | COMMIT_WIDTH*3 | Per-slot failure cause |
| ret_uid_i | input | COMMIT_WIDTH*UID_W | Per-slot transaction UID |
| irq_pending_i | input | 1 | Interrupt pending |
| abort_cmd_i | input | 1 | Abort the named thread's transaction |
| abort_tid_i | input | TID_W | Thread being aborted |
| abort_cause_i | input | 3 | Abort failure cause |
| abort_uid_i | input | UID_W | Aborted transaction UID |
| drain_req_i | input | 1 | Pipeline drain requested |
| deact_req_i | input | 1 | Thread deactivation requested |
| deact_tid_i | input | TID_W | Thread to deactivate |
| in_txn_o | output | NUM_THREADS | Per-thread transactional status |
| trap_valid_o | output | 1 | Trap request |
| trap_code_o | output | 4 | Trap fault code |
| trap_cause_o | output | 3 | Trap failure cause |
| trap_uid_o | output | UID_W | Trap UID |
| irq_take_o | output | 1 | Take the pending interrupt |
| irq_clear_o | output | 1 | Clear and drop the pending interrupt |
| spin_guard_o | output | 1 | Quiesce-livelock avoidance flag |
| abort_valid_o | output | 1 | Abort request to data cache |
| abort_addr_o | output | ADDR_W | Abort request address (0) |
| abort_bytes_o | output | 4 | Abort request size in bytes |
| abort_attr_o | output | 3 | {abort, strictly ordered, physical} |
| abort_cause_o | output | 3 | Abort cause |
| abort_uid_o | output | UID_W | Abort UID |
| last_uid_valid_o | output | 1 | Last-retired begin UID update |
| last_uid_o | output | UID_W | Last-retired begin UID |
| check_err_o | output | 1 | Tag/state mismatch |
| drain_err_o | output | 1 | Drain during transaction |
| deact_err_o | output | 1 | Deactivation during transaction |

## Verification
Two functions can land in the same cycle: an abort and a retirement group on the same thread. Both try to write that thread's counters. The bench provokes this by putting one thread inside a transaction, then asserting `abort_cmd_i` in the same cycle that a begin retires on that thread while the other thread is also transactional. It judges the result by checking that the aborted thread reads as not transactional on the next cycle, that the other thread is untouched, and that the abort request fields are correct. A second overlap puts a pending interrupt together with a begin that retires on a non-transactional thread. The expected outcome there is that the interrupt is taken, because it is judged on the state before the group.

// File: rtl/txn_mon_pkg.sv
package txn_mon_pkg;
    localparam int FAULT_W = 4;
    localparam logic [FAULT_W-1:0] FAULT_NONE = 4'd0;
    localparam logic [FAULT_W-1:0] FAULT_TXN  = 4'd1;

    typedef enum logic [2:0] {
        CAUSE_INVALID   = 3'd0,
        CAUSE_EXCEPTION = 3'd1,
        CAUSE_SIZE      = 3'd2,
        CAUSE_MEMORY    = 3'd3,
        CAUSE_OTHER     = 3'd4
    } fail_cause_e;
endpackage

// File: rtl/txn_depth_bank.sv
module txn_depth_bank #(
    parameter int T     = 2,
    parameter int CNT_W = 6,
    parameter int TID_W = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [TID_W-1:0] wr_tid_i,
    input  logic [CNT_W-1:0] wr_starts_i,
    input  logic [CNT_W-1:0] wr_stops_i,
    input  logic             clr_en_i,
    input  logic [TID_W-1:0] clr_tid_i,
    input  logic [TID_W-1:0] rd_tid_i,
    output logic [CNT_W-1:0] rd_starts_o,
    output logic [CNT_W-1:0] rd_stops_o,
    output logic [T-1:0]     in_txn_o
);
    logic [T-1:0][CNT_W-1:0] starts_d, starts_q, stops_d, stops_q;

    always_comb begin
        starts_d = starts_q;
        stops_d  = stops_q;
        if (wr_en_i) begin
            starts_d[wr_tid_i] = wr_starts_i;
            stops_d[wr_tid_i]  = wr_stops_i;
        end
        // abort has priority over same-cycle retirement
        if (clr_en_i) begin
            starts_d[clr_tid_i] = '0;
            stops_d[clr_tid_i]  = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            starts_q <= '0;
            stops_q  <= '0;
        end else begin
            starts_q <= starts_d;
            stops_q  <= stops_d;
        end
    end

    assign rd_starts_o = starts_q[rd_tid_i];
    assign rd_stops_o  = stops_q[rd_tid_i];

    for (genvar g = 0; g < T; g++) begin : g_status
        assign in_txn_o[g] = starts_q[g] > stops_q[g];
    end

    // R7: an abort leaves the named thread with zeroed counters
    a_r7_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_en_i |=> (starts_q[$past(clr_tid_i)] == '0 && stops_q[$past(clr_tid_i)] == '0));
endmodule

// File: rtl/txn_retire_scan.sv
module txn_retire_scan
    import txn_mon_pkg::*;
#(
    parameter int W     = 2,
    parameter int CNT_W = 6,
    parameter int UID_W = 16
) (
    input  logic                      active_i,
    input  logic [CNT_W-1:0]          starts_i,
    input  logic [CNT_W-1:0]          stops_i,
    input  logic [W-1:0]              valid_i,
    input  logic [W-1:0]              start_i,
    input  logic [W-1:0]              stop_i,
    input  logic [W-1:0]              tagged_i,
    input  logic [W-1:0][FAULT_W-1:0] fault_i,
    input  logic [W-1:0][2:0]         cause_i,
    input  logic [W-1:0][UID_W-1:0]   uid_i,
    output logic [CNT_W-1:0]          starts_o,
    output logic [CNT_W-1:0]          stops_o,
    output logic                      mismatch_o,
    output logic                      fault_hit_o,
    output logic [FAULT_W-1:0]        fault_code_o,
    output logic [2:0]                fault_cause_o,
    output logic                      fault_tagged_o,
    output logic [UID_W-1:0]          fault_uid_o,
    output logic                      uid_hit_o,
    output logic [UID_W-1:0]          uid_o
);
    always_comb begin
        logic live;
        live           = active_i;
        starts_o       = starts_i;
        stops_o        = stops_i;
        mismatch_o     = 1'b0;
        fault_hit_o    = 1'b0;
        fault_code_o   = FAULT_NONE;
        fault_cause_o  = '0;
        fault_tagged_o = 1'b0;
        fault_uid_o    = '0;
        uid_hit_o      = 1'b0;
        uid_o          = '0;
        for (int i = 0; i < W; i++) begin
            if (live && valid_i[i]) begin
                if (fault_i[i] != FAULT_NONE) begin
                    // oldest fault wins; it and younger slots do not retire
                    fault_hit_o    = 1'b1;
                    fault_code_o   = fault_i[i];
                    fault_cause_o  = cause_i[i];
                    fault_tagged_o = tagged_i[i];
                    fault_uid_o    = uid_i[i];
                    live           = 1'b0;
                end else begin
                    if (start_i[i]) starts_o = starts_o + 1'b1;
                    if (tagged_i[i] != (starts_o > stops_o)) mismatch_o = 1'b1;
                    if (stop_i[i]) stops_o = stops_o + 1'b1;
                    if (start_i[i]) begin
                        uid_hit_o = 1'b1;
                        uid_o     = uid_i[i];
                    end
                end
            end
        end
    end
endmodule

// File: rtl/txn_fault_xlate.sv
module txn_fault_xlate
    import txn_mon_pkg::*;
#(
    parameter int UID_W = 16
) (
    input  logic [FAULT_W-1:0] code_i,
    input  logic [2:0]         cause_i,
    input  logic               tagged_i,
    input  logic [UID_W-1:0]   uid_i,
    output logic [FAULT_W-1:0] code_o,
    output fail_cause_e        cause_o,
    output logic [UID_W-1:0]   uid_o
);
    always_comb begin
        code_o  = code_i;
        cause_o = fail_cause_e'(cause_i);
        uid_o   = uid_i;
        if (tagged_i && code_i != FAULT_NONE && code_i != FAULT_TXN) begin
            code_o  = FAULT_TXN;
            cause_o = CAUSE_EXCEPTION;
        end
    end
endmodule

// File: rtl/txn_commit_monitor.sv
module txn_commit_monitor
    import txn_mon_pkg::*;
#(
    parameter int NUM_THREADS  = 2,
    parameter int COMMIT_WIDTH = 2,
    parameter int UID_W        = 16,
    parameter int CNT_W        = 6,
    parameter int ADDR_W       = 32,
    localparam int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic [TID_W-1:0]                     commit_tid_i,
    input  logic                                 commit_tid_valid_i,
    input  logic [COMMIT_WIDTH-1:0]              ret_valid_i,
    input  logic [COMMIT_WIDTH-1:0]              ret_start_i,
    input  logic [COMMIT_WIDTH-1:0]              ret_stop_i,
    input  logic [COMMIT_WIDTH-1:0]              ret_tagged_i,
    input  logic [COMMIT_WIDTH-1:0][FAULT_W-1:0] ret_fault_i,
    input  logic [COMMIT_WIDTH-1:0][2:0]         ret_cause_i,
    input  logic [COMMIT_WIDTH-1:0][UID_W-1:0]   ret_uid_i,
    input  logic                                 irq_pending_i,
    input  logic                                 abort_cmd_i,
    input  logic [TID_W-1:0]                     abort_tid_i,
    input  logic [2:0]                           abort_cause_i,
    input  logic [UID_W-1:0]                     abort_uid_i,
    input  logic                                 drain_req_i,
    input  logic                                 deact_req_i,
    input  logic [TID_W-1:0]                     deact_tid_i,
    output logic [NUM_THREADS-1:0]               in_txn_o,
    output logic                                 trap_valid_o,
    output logic [FAULT_W-1:0]                   trap_code_o,
    output logic [2:0]                           trap_cause_o,
    output logic [UID_W-1:0]                     trap_uid_o,
    output logic                                 irq_take_o,
    output logic                                 irq_clear_o,
    output logic                                 spin_guard_o,
    output logic                                 abort_valid_o,
    output logic [ADDR_W-1:0]                    abort_addr_o,
    output logic [3:0]                           abort_bytes_o,
    output logic [2:0]                           abort_attr_o,
    output logic [2:0]                           abort_cause_o,
    output logic [UID_W-1:0]                     abort_uid_o,
    output logic                                 last_uid_valid_o,
    output logic [UID_W-1:0]                     last_uid_o,
    output logic                                 check_err_o,
    output logic                                 drain_err_o,
    output logic                                 deact_err_o
);
    localparam logic [3:0] ABORT_BYTES = 4'd8;

    typedef struct packed {
        logic               trap_valid;
        logic [FAULT_W-1:0] trap_code;
        fail_cause_e        trap_cause;
        logic [UID_W-1:0]   trap_uid;
        logic               irq_take;
        logic               irq_clear;
        logic               spin_guard;
        logic               abort_valid;
        logic [2:0]         abort_cause;
        logic [UID_W-1:0]   abort_uid;
        logic               uid_valid;
        logic [UID_W-1:0]   uid;
        logic               check_err;
        logic               drain_err;
        logic               deact_err;
    } out_t;

    out_t out_d, out_q;

    logic [CNT_W-1:0]   cur_starts, cur_stops, new_starts, new_stops;
    logic               mismatch, fault_hit, fault_tagged, uid_hit, cur_in_txn;
    logic [FAULT_W-1:0] fault_code, xl_code;
    logic [2:0]         fault_cause;
    fail_cause_e        xl_cause;
    logic [UID_W-1:0]   fault_uid, xl_uid, scan_uid;

    txn_depth_bank #(.T(NUM_THREADS), .CNT_W(CNT_W), .TID_W(TID_W)) i_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (commit_tid_valid_i),
        .wr_tid_i   (commit_tid_i),
        .wr_starts_i(new_starts),
        .wr_stops_i (new_stops),
        .clr_en_i   (abort_cmd_i),
        .clr_tid_i  (abort_tid_i),
        .rd_tid_i   (commit_tid_i),
        .rd_starts_o(cur_starts),
        .rd_stops_o (cur_stops),
        .in_txn_o   (in_txn_o)
    );

    txn_retire_scan #(.W(COMMIT_WIDTH), .CNT_W(CNT_W), .UID_W(UID_W)) i_scan (
        .active_i      (commit_tid_valid_i),
        .starts_i      (cur_starts),
        .stops_i       (cur_stops),
        .valid_i       (ret_valid_i),
        .start_i       (ret_start_i),
        .stop_i        (ret_stop_i),
        .tagged_i      (ret_tagged_i),
        .fault_i       (ret_fault_i),
        .cause_i       (ret_cause_i),
        .uid_i         (ret_uid_i),
        .starts_o      (new_starts),
        .stops_o       (new_stops),
        .mismatch_o    (mismatch),
        .fault_hit_o   (fault_hit),
        .fault_code_o  (fault_code),
        .fault_cause_o (fault_cause),
        .fault_tagged_o(fault_tagged),
        .fault_uid_o   (fault_uid),
        .uid_hit_o     (uid_hit),
        .uid_o         (scan_uid)
    );

    txn_fault_xlate #(.UID_W(UID_W)) i_xlate (
        .code_i  (fault_code),
        .cause_i (fault_cause),
        .tagged_i(fault_tagged),
        .uid_i   (fault_uid),
        .code_o  (xl_code),
        .cause_o (xl_cause),
        .uid_o   (xl_uid)
    );

    assign cur_in_txn = commit_tid_valid_i && in_txn_o[commit_tid_i];

    always_comb begin
        out_d             = '0;
        out_d.trap_cause  = CAUSE_INVALID;
        out_d.trap_valid  = fault_hit;
        if (fault_hit) begin
            out_d.trap_code  = xl_code;
            out_d.trap_cause = xl_cause;
            out_d.trap_uid   = xl_uid;
        end
        out_d.irq_take    = irq_pending_i && !cur_in_txn;
        out_d.irq_clear   = irq_pending_i && cur_in_txn;
        out_d.spin_guard  = irq_pending_i && cur_in_txn;
        out_d.abort_valid = abort_cmd_i;
        if (abort_cmd_i) begin
            out_d.abort_cause = abort_cause_i;
            out_d.abort_uid   = abort_uid_i;
        end
        out_d.uid_valid = uid_hit;
        out_d.uid       = uid_hit ? scan_uid : '0;
        out_d.check_err = mismatch;
        out_d.drain_err = drain_req_i && (|in_txn_o);
        out_d.deact_err = deact_req_i && in_txn_o[deact_tid_i];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q            <= '0;
            out_q.trap_cause <= CAUSE_INVALID;
        end else begin
            out_q <= out_d;
        end
    end

    assign trap_valid_o     = out_q.trap_valid;
    assign trap_code_o      = out_q.trap_code;
    assign trap_cause_o     = out_q.trap_cause;
    assign trap_uid_o       = out_q.trap_uid;
    assign irq_take_o       = out_q.irq_take;
    assign irq_clear_o      = out_q.irq_clear;
    assign spin_guard_o     = out_q.spin_guard;
    assign abort_valid_o    = out_q.abort_valid;
    assign abort_addr_o     = '0;
    assign abort_bytes_o    = out_q.abort_valid ? ABORT_BYTES : 4'd0;
    assign abort_attr_o     = out_q.abort_valid ? 3'b111 : 3'b000;
    assign abort_cause_o    = out_q.abort_cause;
    assign abort_uid_o      = out_q.abort_uid;
    assign last_uid_valid_o = out_q.uid_valid;
    assign last_uid_o       = out_q.uid;
    assign check_err_o      = out_q.check_err;
    assign drain_err_o      = out_q.drain_err;
    assign deact_err_o      = out_q.deact_err;

    // R4: a pending interrupt is either taken or dropped, never both
    a_r4_irq_one_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(irq_take_o && irq_clear_o));
    // R4: dropping an interrupt always raises the livelock guard
    a_r4_spin_with_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_clear_o |-> spin_guard_o);
    // R2: with no retirement and no abort the status is held
    a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!commit_tid_valid_i && !abort_cmd_i) |=> $stable(in_txn_o));
    // R5: a tagged slot-0 fault always traps as a transactional failure
    a_r5_slot0_rewrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_tid_valid_i && ret_valid_i[0] && ret_tagged_i[0] &&
         ret_fault_i[0] != FAULT_NONE) |=> (trap_valid_o && trap_code_o == FAULT_TXN));
    // R9: draining with a transactional thread is flagged
    a_r9_drain_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drain_req_i && (|in_txn_o)) |=> drain_err_o);
endmodule

// File: tb/test_txn_commit_monitor.sv
module test_txn_commit_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int T   = 2;
    localparam int W   = 2;
    localparam int UW  = 16;
    localparam int NV  = 9;
    // {tid, v0,st0,sp0,tg0, v1,st1,sp1,tg1, exp_in_txn[1:0], exp_check_err}
    localparam logic [NV-1:0][11:0] VEC = {
        12'b1_1010_0000_00_1,
        12'b1_1100_0000_10_1,
        12'b0_1001_0000_00_1,
        12'b0_1000_0000_00_0,
        12'b0_1101_1011_00_0,
        12'b1_1011_1011_00_0,
        12'b1_1101_1101_10_0,
        12'b0_1001_1011_00_0,
        12'b0_1101_0000_01_0
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [0:0] commit_tid, abort_tid, deact_tid;
    logic commit_tid_valid, irq_pending, abort_cmd, drain_req, deact_req;
    logic [W-1:0] ret_valid, ret_start, ret_stop, ret_tagged;
    logic [W-1:0][3:0] ret_fault;
    logic [W-1:0][2:0] ret_cause;
    logic [W-1:0][UW-1:0] ret_uid;
    logic [2:0] abort_cause;
    logic [UW-1:0] abort_uid;
    logic [T-1:0] in_txn;
    logic trap_valid, irq_take, irq_clear, spin_guard, abort_valid;
    logic [3:0] trap_code, abort_bytes;
    logic [2:0] trap_cause, abort_attr, abort_cause_out;
    logic [UW-1:0] trap_uid, abort_uid_out, last_uid;
    logic [31:0] abort_addr;
    logic last_uid_valid, check_err, drain_err, deact_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txn_commit_monitor i_txn_commit_monitor (
        .clk_i(clk), .rst_ni(rst_n),
        .commit_tid_i(commit_tid), .commit_tid_valid_i(commit_tid_valid),
        .ret_valid_i(ret_valid), .ret_start_i(ret_start), .ret_stop_i(ret_stop),
        .ret_tagged_i(ret_tagged), .ret_fault_i(ret_fault), .ret_cause_i(ret_cause),
        .ret_uid_i(ret_uid), .irq_pending_i(irq_pending),
        .abort_cmd_i(abort_cmd), .abort_tid_i(abort_tid),
        .abort_cause_i(abort_cause), .abort_uid_i(abort_uid),
        .drain_req_i(drain_req), .deact_req_i(deact_req), .deact_tid_i(deact_tid),
        .in_txn_o(in_txn), .trap_valid_o(trap_valid), .trap_code_o(trap_code),
        .trap_cause_o(trap_cause), .trap_uid_o(trap_uid),
        .irq_take_o(irq_take), .irq_clear_o(irq_clear), .spin_guard_o(spin_guard),
        .abort_valid_o(abort_valid), .abort_addr_o(abort_addr),
        .abort_bytes_o(abort_bytes), .abort_attr_o(abort_attr),
        .abort_cause_o(abort_cause_out), .abort_uid_o(abort_uid_out),
        .last_uid_valid_o(last_uid_valid), .last_uid_o(last_uid),
        .check_err_o(check_err), .drain_err_o(drain_err), .deact_err_o(deact_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        commit_tid = '0; commit_tid_valid = 1'b0;
        ret_valid = '0; ret_start = '0; ret_stop = '0; ret_tagged = '0;
        ret_fault = '0; ret_cause = '0; ret_uid = '0;
        irq_pending = 1'b0; abort_cmd = 1'b0; abort_tid = '0;
        abort_cause = '0; abort_uid = '0;
        drain_req = 1'b0; deact_req = 1'b0; deact_tid = '0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < 20000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 reset in_txn", in_txn, 0);
        chk("R1 reset pulses", {trap_valid, irq_take, irq_clear, abort_valid, check_err}, 0);

        // R2/R3 table
        for (int k = 0; k < NV; k++) begin
            automatic logic [11:0] e = VEC[k];
            idle();
            commit_tid = e[11]; commit_tid_valid = 1'b1;
            ret_valid  = {e[6], e[10]};
            ret_start  = {e[5], e[9]};
            ret_stop   = {e[4], e[8]};
            ret_tagged = {e[3], e[7]};
            step();
            chk("R2 in_txn", in_txn, e[2:1]);
            chk("R3 check_err", check_err, e[0]);
        end

        // R1: invalid thread reads non-transactional, counts nothing
        idle(); commit_tid_valid = 1'b1; ret_valid = 2'b01; ret_start = 2'b01; ret_tagged = 2'b01;
        step();
        chk("R1 enter t0", in_txn, 2'b01);
        idle(); ret_valid = 2'b01; ret_start = 2'b01; ret_tagged = 2'b01; irq_pending = 1'b1;
        step();
        chk("R1 invalid tid irq taken", irq_take, 1);
        chk("R1 invalid tid no count", in_txn, 2'b01);

        // R4: interrupt dropped in transaction
        idle(); commit_tid_valid = 1'b1; irq_pending = 1'b1;
        step();
        chk("R4 irq_clear", irq_clear, 1);
        chk("R4 spin_guard", spin_guard, 1);
        chk("R4 irq_take", irq_take, 0);
        // R4: judged on state before the group (t1 not in txn, begin retiring)
        idle(); commit_tid = 1'b1; commit_tid_valid = 1'b1; irq_pending = 1'b1;
        ret_valid = 2'b01; ret_start = 2'b01; ret_tagged = 2'b01;
        step();
        chk("R4 prior state take", {irq_take, irq_clear}, 2'b10);
        idle(); commit_tid = 1'b1; commit_tid_valid = 1'b1;
        ret_valid = 2'b01; ret_stop = 2'b01; ret_tagged = 2'b01;
        step();
        chk("R4 restore t1", in_txn, 2'b01);

        // R8: youngest begin UID reported
        idle(); commit_tid_valid = 1'b1; ret_valid = 2'b11; ret_start = 2'b11; ret_tagged = 2'b11;
        ret_uid[0] = 16'h0011; ret_uid[1] = 16'h0022;
        step();
        chk("R8 uid valid", last_uid_valid, 1);
        chk("R8 uid value", last_uid, 16'h0022);

        // R5: rewrite rules
        idle(); commit_tid_valid = 1'b1; ret_valid = 2'b01; ret_tagged = 2'b01;
        ret_fault[0] = 4'd5; ret_cause[0] = 3'd3; ret_uid[0] = 16'h0033;
        step();
        chk("R5 tagged rewrite", {trap_valid, trap_code, trap_cause, trap_uid}, {1'b1, 4'd1, 3'd1, 16'h0033});
        idle(); commit_tid_valid = 1'b1; ret_valid = 2'b01; ret_tagged = 2'b01;
        ret_fault[0] = 4'd1; ret_cause[0] = 3'd3; ret_uid[0] = 16'h0034;
        step();
        chk("R5 txn fault kept", {trap_code, trap_cause}, {4'd1, 3'd3});
        idle(); commit_tid = 1'b1; commit_tid_valid = 1'b1; ret_valid = 2'b01;
        ret_fault[0] = 4'd6; ret_cause[0] = 3'd0;
        step();
        chk("R5 untagged pass", {trap_valid, trap_code, trap_cause}, {1'b1, 4'd6, 3'd0});
        chk("R5 no count", in_txn, 2'b01);

        // R6: oldest fault wins, younger slots not counted
        idle(); commit_tid = 1'b1; commit_tid_valid = 1'b1; ret_valid = 2'b11;
        ret_start = 2'b01; ret_tagged = 2'b11; ret_fault[1] = 4'd2; ret_uid[1] = 16'h0055;
        step();
        chk("R6 slot1 trap", {trap_code, trap_cause, trap_uid}, {4'd1, 3'd1, 16'h0055});
        chk("R6 slot0 counted", in_txn, 2'b11);
        idle(); commit_tid = 1'b1; commit_tid_valid = 1'b1; ret_valid = 2'b11;
        ret_start = 2'b10; ret_tagged = 2'b10; ret_fault[0] = 4'd7;
        step();
        chk("R6 slot0 trap code", trap_code, 4'd7);
        chk("R6 younger ignored", {in_txn, last_uid_valid}, {2'b11, 1'b0});

        // R7: abort overlapping a retirement on the same thread
        idle(); commit_tid_valid = 1'b1; ret_valid = 2'b01; ret_start = 2'b01; ret_tagged = 2'b01;
        abort_cmd = 1'b1; abort_tid = 1'b0; abort_cause = 3'd3; abort_uid = 16'h0044;
        step();
        chk("R7 cleared, other kept", in_txn, 2'b10);
        chk("R7 request", {abort_valid, abort_addr, abort_bytes, abort_attr, abort_cause_out, abort_uid_out},
            {1'b1, 32'd0, 4'd8, 3'b111, 3'd3, 16'h0044});

        // R9: drain and deactivate during a transaction
        idle(); drain_req = 1'b1;
        step();
        chk("R9 drain_err", drain_err, 1);
        idle(); deact_req = 1'b1; deact_tid = 1'b1;
        step();
        chk("R9 deact busy", deact_err, 1);
        idle(); deact_req = 1'b1; deact_tid = 1'b0;
        step();
        chk("R9 deact idle thread", deact_err, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule